// File: doc/BRIEF.md
# Time-Sliced Hardware Task Context Manager

This block sits beside the issue stage of a pipelined processor core and runs up to four hardware tasks on it. A sixteen-entry slot table picks the task for each issue cycle. A pointer walks the table one entry per cycle. A supervisor rewrites the table to take all slots away from a task or to hand slots back. For every task the block holds the architectural context: program counter, Z and C flags, a four-level call/return stack, and a data-cache address with its valid bit. Execution is modelled only by a small operation code (step, jump, call, return) and a flag write, which the block applies to the task issuing in that cycle.

The supervisor drives a command port. A read command packs a whole task context into one 256-bit word, once the task has drained from the pipeline. A write command loads a whole context from a 256-bit word. Two wide-load variants fill the wide data register; one of them also records the cache line for a task. Per-task stall bits turn a task's slots into null issues, and a step command lets one instruction of a stalled task through. Together these let one task preempt, save, restore and single-step the others.

Top module: `task_ctx_mgr`

## Requirements
- R1: After reset every slot names task 0, task 0 runs, tasks 1 to 3 are stalled, and every context field and the wide register are zero.
- R2: Slot i of the table is `tableIn[2i+1:2i]`. The slot pointer advances one entry per cycle and wraps after slot 15. A table write is used from the next cycle on, and a task with no entry never issues.
- R3: In a slot of a stalled task `issueValid` is 0 and that task's PC does not change.
- R4: For the issuing task, `exOp` 0 adds one to the PC, 3 loads `exTarget`, 1 pushes the entry {C, Z, PC+1} and loads `exTarget`, and 2 pops the top entry into C, Z and PC. The stack shifts: a push drops the deepest entry and a pop clears it. `exFlagWe` writes `exZ` and `exC`, except on a return.
- R5: The packed context is PC in bits 15:0, Z in bit 16, C in bit 17, stack entries from the top downward in bits 35:18, 53:36, 71:54 and 89:72 (each {C,Z,PC}), cache address in bits 105:90 and cache valid in bit 106. All higher bits read as zero.
- R6: Read (`cmdOp` 0) raises `rdBusy` at the next edge. It keeps `rdBusy` high while the target still issues or has an instruction among the last three issues. It then puts the packed context on `wideOut`, drops `rdBusy` and pulses `rdDone` for one cycle.
- R7: Write (`cmdOp` 1) loads the target's whole context, including the cache fields, from `wideIn`. Bits of `wideIn` above bit 106 are ignored.
- R8: Wide load (`cmdOp` 2) puts `wideIn` into the wide register and sets the target's cache address to `cmdAddr` and its valid bit to 1. The quiet wide load (`cmdOp` 3) changes the wide register only.
- R9: Step (`cmdOp` 6) on a stalled task lets the next slot of that task issue one real instruction. The task's later slots are null again.
- R10: A read or write naming the task that issues in that same cycle is ignored, and `cmdErr` is high for the following cycle.
- R11: Any command given while `rdBusy` is high is ignored.
- R12: Stall (`cmdOp` 4) and run (`cmdOp` 5) set and clear a task's stall bit, and the change applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tableWrEn | input | 1 | Replace the slot table |
| tableIn | input | 32 | New slot table, two bits per slot |
| cmdValid | input | 1 | Supervisor command present |
| cmdOp | input | 3 | Command code |
| cmdTask | input | 2 | Task the command targets |
| cmdAddr | input | 16 | Cache address for a wide load |
| wideIn | input | 256 | Wide word for a write or wide load |
| exOp | input | 2 | Operation of the issuing instruction |
| exTarget | input | 16 | Jump or call target |
| exFlagWe | input | 1 | Write the flags |
| exZ | input | 1 | New Z flag |
| exC | input | 1 | New C flag |
| issueTask | output | 2 | Task owning the current slot |
| issueValid | output | 1 | Real instruction issues (0 means a null) |
| issuePc | output | 16 | PC of the task owning the current slot |
| wideOut | output | 256 | Wide data register |
| rdBusy | output | 1 | Context read waiting for drain |
| rdDone | output | 1 | Snapshot is on wideOut |
| cmdErr | output | 1 | Previous read/write named the issuing task |

## Verification
The bench reads a task while it still holds alternate slots and checks that the snapshot waits until the task is starved. A design that skipped the drain would return a context that still changes. It pushes two calls with different flags and then returns. A wrong entry order or flag placement shows up as a swapped stack or wrong flags in the snapshot. It sends a write whose high bits are all ones, a quiet wide load, and a wide load during a busy read. A design that kept high bits, touched cache fields on the quiet load, or accepted commands while busy would return changed snapshots. Finally it steps a stalled task once. A design that did not re-stall the task would show a second valid issue and a PC that moves on.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int NUM_TASKS  = 4;
  localparam int SLOTS      = 16;
  localparam int PC_W       = 16;
  localparam int STK_DEPTH  = 4;
  localparam int DC_W       = 16;
  localparam int WIDE_W     = 256;
  localparam int PIPE_DEPTH = 3;

  localparam int TASK_W  = $clog2(NUM_TASKS);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int ENTRY_W = PC_W + 2;
  localparam int STK_W   = STK_DEPTH * ENTRY_W;
  localparam int CTX_W   = ENTRY_W + STK_W + DC_W + 1;

  typedef logic [TASK_W-1:0] taskId_t;

  typedef enum logic [2:0] {
    CMD_RDTASK = 3'd0,
    CMD_WRTASK = 3'd1,
    CMD_LDWIDE = 3'd2,
    CMD_LDWQ   = 3'd3,
    CMD_STALL  = 3'd4,
    CMD_RUN    = 3'd5,
    CMD_STEP   = 3'd6,
    CMD_RSVD   = 3'd7
  } cmdOp_e;

  typedef enum logic [1:0] {
    EX_NEXT = 2'd0,
    EX_CALL = 2'd1,
    EX_RET  = 2'd2,
    EX_JUMP = 2'd3
  } exOp_e;

  // packed context, least significant field last
  typedef struct packed {
    logic             dcV;
    logic [DC_W-1:0]  dcA;
    logic [STK_W-1:0] stk;
    logic             c;
    logic             z;
    logic [PC_W-1:0]  pc;
  } ctx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    exEn;
    taskId_t exTask;
    logic    snapEn;
    taskId_t snapTask;
    logic    loadEn;
    taskId_t loadTask;
    logic    wideLdEn;
    logic    dcSetEn;
    taskId_t dcTask;
  } strobe_t;
endpackage

// File: rtl/tcm_dpath.sv
module tcm_dpath
  import tcm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  exOp_e             exOp,
  input  logic [PC_W-1:0]   exTarget,
  input  logic              exFlagWe,
  input  logic              exZ,
  input  logic              exC,
  input  logic [DC_W-1:0]   cmdAddr,
  input  logic [WIDE_W-1:0] wideIn,
  output logic [PC_W-1:0]   curPc,
  output logic [WIDE_W-1:0] wideOut
);
  ctx_t ctxR [NUM_TASKS];
  ctx_t curCtx;
  ctx_t execNext;
  logic [WIDE_W-1:0] wideR;

  assign curCtx  = ctxR[strb.exTask];
  assign curPc   = curCtx.pc;
  assign wideOut = wideR;

  // next context of the issuing task
  always_comb begin
    execNext = curCtx;
    case (exOp)
      EX_NEXT: execNext.pc = curCtx.pc + PC_W'(1);
      EX_JUMP: execNext.pc = exTarget;
      EX_CALL: begin
        execNext.stk = {curCtx.stk[STK_W-ENTRY_W-1:0], curCtx.c, curCtx.z,
                        PC_W'(curCtx.pc + PC_W'(1))};
        execNext.pc  = exTarget;
      end
      EX_RET: begin
        {execNext.c, execNext.z, execNext.pc} = curCtx.stk[ENTRY_W-1:0];
        execNext.stk = {{ENTRY_W{1'b0}}, curCtx.stk[STK_W-1:ENTRY_W]};
      end
      default: execNext = curCtx;
    endcase
    if (exFlagWe && exOp != EX_RET) begin
      execNext.z = exZ;
      execNext.c = exC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TASKS; t++) ctxR[t] <= '0;
      wideR <= '0;
    end else begin
      for (int t = 0; t < NUM_TASKS; t++) begin
        if (strb.loadEn && strb.loadTask == TASK_W'(t)) begin
          ctxR[t] <= ctx_t'(wideIn[CTX_W-1:0]);
        end else begin
          if (strb.exEn && strb.exTask == TASK_W'(t)) ctxR[t] <= execNext;
          if (strb.dcSetEn && strb.dcTask == TASK_W'(t)) begin
            ctxR[t].dcA <= cmdAddr;
            ctxR[t].dcV <= 1'b1;
          end
        end
      end
      if (strb.snapEn)
        wideR <= {{(WIDE_W-CTX_W){1'b0}}, ctxR[strb.snapTask]};
      else if (strb.wideLdEn)
        wideR <= wideIn;
    end
  end
endmodule

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tableWrEn,
  input  logic [SLOTS*TASK_W-1:0]  tableIn,
  input  logic                     cmdValid,
  input  cmdOp_e                   cmdOp,
  input  taskId_t                  cmdTask,
  output strobe_t                  strb,
  output taskId_t                  issueTask,
  output logic                     issueValid,
  output logic                     rdBusy,
  output logic                     rdDone,
  output logic                     cmdErr
);
  taskId_t               slotTab [SLOTS];
  logic [SLOT_W-1:0]     slotPtr;
  logic [NUM_TASKS-1:0]  stallMask;
  logic [NUM_TASKS-1:0]  stepPend;
  logic [PIPE_DEPTH-1:0] pipeVld;
  taskId_t               pipeTask [PIPE_DEPTH];
  logic [PIPE_DEPTH-1:0] pipeHit;
  logic                  rdPend;
  taskId_t               rdTask;
  logic                  rdPendDone;

  logic cmdAccept, ctxOp, selfHit, badCmd, capture;

  assign issueTask  = slotTab[slotPtr];
  assign issueValid = !stallMask[issueTask] || stepPend[issueTask];

  for (genvar g = 0; g < PIPE_DEPTH; g++) begin : gHit
    assign pipeHit[g] = pipeVld[g] && (pipeTask[g] == rdTask);
  end

  assign cmdAccept = cmdValid && !rdPend;
  assign ctxOp     = (cmdOp == CMD_RDTASK) || (cmdOp == CMD_WRTASK);
  assign selfHit   = issueValid && (issueTask == cmdTask);
  assign badCmd    = cmdAccept && ctxOp && selfHit;
  assign capture   = rdPend && !(|pipeHit) && !(issueValid && issueTask == rdTask);

  always_comb begin
    strb          = '0;
    strb.exEn     = issueValid;
    strb.exTask   = issueTask;
    strb.snapEn   = capture;
    strb.snapTask = rdTask;
    strb.loadEn   = cmdAccept && (cmdOp == CMD_WRTASK) && !selfHit;
    strb.loadTask = cmdTask;
    strb.wideLdEn = cmdAccept && ((cmdOp == CMD_LDWIDE) || (cmdOp == CMD_LDWQ));
    strb.dcSetEn  = cmdAccept && (cmdOp == CMD_LDWIDE);
    strb.dcTask   = cmdTask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) slotTab[i] <= '0;
      slotPtr   <= '0;
      stallMask <= {{(NUM_TASKS-1){1'b1}}, 1'b0};
      stepPend  <= '0;
      pipeVld   <= '0;
      for (int i = 0; i < PIPE_DEPTH; i++) pipeTask[i] <= '0;
      rdPend    <= 1'b0;
      rdTask    <= '0;
      rdPendDone <= 1'b0;
      cmdErr    <= 1'b0;
    end else begin
      slotPtr <= slotPtr + SLOT_W'(1);
      if (tableWrEn)
        for (int i = 0; i < SLOTS; i++) slotTab[i] <= tableIn[i*TASK_W +: TASK_W];

      pipeVld     <= {pipeVld[PIPE_DEPTH-2:0], issueValid};
      pipeTask[0] <= issueTask;
      for (int i = 1; i < PIPE_DEPTH; i++) pipeTask[i] <= pipeTask[i-1];

      if (issueValid) stepPend[issueTask] <= 1'b0;

      if (cmdAccept) begin
        case (cmdOp)
          CMD_STALL: stallMask[cmdTask] <= 1'b1;
          CMD_RUN:   stallMask[cmdTask] <= 1'b0;
          CMD_STEP:  if (stallMask[cmdTask]) stepPend[cmdTask] <= 1'b1;
          CMD_RDTASK: if (!selfHit) begin
            rdPend <= 1'b1;
            rdTask <= cmdTask;
          end
          default: ;
        endcase
      end
      if (capture) rdPend <= 1'b0;
      rdPendDone <= capture;
      cmdErr     <= badCmd;
    end
  end

  assign rdBusy = rdPend;
  assign rdDone = rdPendDone;
endmodule

// File: rtl/task_ctx_mgr.sv
module task_ctx_mgr
  import tcm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tableWrEn,
  input  logic [SLOTS*TASK_W-1:0]  tableIn,
  input  logic                     cmdValid,
  input  logic [2:0]               cmdOp,
  input  logic [TASK_W-1:0]        cmdTask,
  input  logic [DC_W-1:0]          cmdAddr,
  input  logic [WIDE_W-1:0]        wideIn,
  input  logic [1:0]               exOp,
  input  logic [PC_W-1:0]          exTarget,
  input  logic                     exFlagWe,
  input  logic                     exZ,
  input  logic                     exC,
  output logic [TASK_W-1:0]        issueTask,
  output logic                     issueValid,
  output logic [PC_W-1:0]          issuePc,
  output logic [WIDE_W-1:0]        wideOut,
  output logic                     rdBusy,
  output logic                     rdDone,
  output logic                     cmdErr
);
  strobe_t strb;

  tcm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tableWrEn  (tableWrEn),
    .tableIn    (tableIn),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp_e'(cmdOp)),
    .cmdTask    (cmdTask),
    .strb       (strb),
    .issueTask  (issueTask),
    .issueValid (issueValid),
    .rdBusy     (rdBusy),
    .rdDone     (rdDone),
    .cmdErr     (cmdErr)
  );

  tcm_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .exOp     (exOp_e'(exOp)),
    .exTarget (exTarget),
    .exFlagWe (exFlagWe),
    .exZ      (exZ),
    .exC      (exC),
    .cmdAddr  (cmdAddr),
    .wideIn   (wideIn),
    .curPc    (issuePc),
    .wideOut  (wideOut)
  );
endmodule

// File: rtl/tcm_chk.sv
module tcm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       rdBusy,
  input logic       rdDone,
  input logic       cmdErr
);
  // R10
  err_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> $past(cmdValid && (cmdOp == 3'd0 || cmdOp == 3'd1)));

  // R10
  err_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> !$rose(rdBusy));

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> ($past(rdBusy) && !rdBusy));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdBusy) |-> $past(cmdValid && cmdOp == 3'd0 && !rdBusy));
endmodule

bind task_ctx_mgr tcm_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .rdBusy   (rdBusy),
  .rdDone   (rdDone),
  .cmdErr   (cmdErr)
);

// File: tb/tb_task_ctx_mgr.sv
module tb_task_ctx_mgr;
  logic         clk = 1'b0;
  logic         rstN;
  logic         tableWrEn;
  logic [31:0]  tableIn;
  logic         cmdValid;
  logic [2:0]   cmdOp;
  logic [1:0]   cmdTask;
  logic [15:0]  cmdAddr;
  logic [255:0] wideIn;
  logic [1:0]   exOp;
  logic [15:0]  exTarget;
  logic         exFlagWe, exZ, exC;
  logic [1:0]   issueTask;
  logic         issueValid;
  logic [15:0]  issuePc;
  logic [255:0] wideOut;
  logic         rdBusy, rdDone, cmdErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  exHold  = 1'b0;
  bit  ended   = 1'b0;

  always #5 clk = ~clk;

  task_ctx_mgr dut (.*);

  task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mkCtx(input logic [15:0] pc, input logic z, input logic c,
      input logic [17:0] s0, input logic [17:0] s1, input logic [17:0] s2, input logic [17:0] s3,
      input logic [15:0] da, input logic dv);
    return {149'b0, dv, da, s3, s2, s1, s0, c, z, pc};
  endfunction

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // idle cycles keep the issuing task in place by jumping to its own PC
  task automatic tick();
    if (!exHold) begin
      exOp = 2'd3; exTarget = issuePc; exFlagWe = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setTable(input logic [31:0] v);
    tableWrEn = 1'b1; tableIn = v;
    tick();
    tableWrEn = 1'b0;
  endtask

  task automatic sendCmd(input logic [2:0] op, input logic [1:0] t,
                         input logic [15:0] a, input logic [255:0] w);
    cmdValid = 1'b1; cmdOp = op; cmdTask = t; cmdAddr = a; wideIn = w;
    tick();
    cmdValid = 1'b0;
  endtask

  task automatic waitSlot(input logic [1:0] t);
    for (int n = 0; n < 40 && issueTask != t; n++) tick();
  endtask

  task automatic runT1(input logic [1:0] op, input logic [15:0] tgt,
                       input logic fw, input logic z, input logic c);
    for (int n = 0; n < 40 && !(issueTask == 2'd1 && issueValid); n++) tick();
    exHold = 1'b1; exOp = op; exTarget = tgt; exFlagWe = fw; exZ = z; exC = c;
    tick();
    exHold = 1'b0;
  endtask

  task automatic readTask(input logic [1:0] t, output logic [255:0] w);
    sendCmd(3'd0, t, 16'h0, '0);
    for (int n = 0; n < 50 && !rdDone; n++) tick();
    check("R6", "rdDone seen", rdDone, 1'b1);
    w = wideOut;
  endtask

  task automatic testReset();
    check("R1", "issueTask", issueTask, 2'd0);
    check("R1", "issueValid", issueValid, 1'b1);
    check("R1", "issuePc", issuePc, 16'h0);
    check("R1", "wideOut", wideOut, '0);
    check("R1", "rdBusy", rdBusy, 1'b0);
    exHold = 1'b1; exOp = 2'd0; exFlagWe = 1'b0;
    repeat (5) tick();
    exHold = 1'b0;
    check("R4", "task0 pc after five steps", issuePc, 16'd5);
  endtask

  task automatic testSelfError();
    sendCmd(3'd1, 2'd0, 16'h0, mkCtx(16'h0EEE, 1, 1, 0, 0, 0, 0, 0, 0));
    check("R10", "cmdErr after write on issuing task", cmdErr, 1'b1);
    check("R10", "task0 pc kept", issuePc, 16'd5);
    tick();
    check("R10", "cmdErr pulse ends", cmdErr, 1'b0);
    sendCmd(3'd0, 2'd0, 16'h0, '0);
    check("R10", "cmdErr after read on issuing task", cmdErr, 1'b1);
    check("R10", "no busy after bad read", rdBusy, 1'b0);
  endtask

  task automatic testTable();
    logic [31:0] pat;
    setTable(32'h5555_5555);
    check("R2", "table write used next cycle", issueTask, 2'd1);
    check("R3", "stalled task1 issues null", issueValid, 1'b0);
    check("R1", "task1 pc zero", issuePc, 16'h0);
    for (int i = 0; i < 16; i++) pat[2*i +: 2] = (i == 0) ? 2'd3 : 2'(i % 3);
    setTable(pat);
    waitSlot(2'd3);
    for (int k = 1; k <= 16; k++) begin
      tick();
      check("R2", $sformatf("slot order step %0d", k), issueTask, (k == 16) ? 2'd3 : 2'(k % 3));
    end
  endtask

  task automatic testExecAndDrain();
    logic [255:0] w;
    int seen1;
    setTable(32'h4444_4444);
    sendCmd(3'd5, 2'd1, 16'h0, '0);
    waitSlot(2'd1);
    check("R12", "task1 runs after run command", issueValid, 1'b1);
    runT1(2'd3, 16'h0100, 0, 0, 0);
    runT1(2'd0, 16'h0, 1, 1, 0);
    runT1(2'd1, 16'h0200, 0, 0, 0);
    runT1(2'd1, 16'h0300, 1, 0, 1);
    waitSlot(2'd1);
    check("R4", "pc after two calls", issuePc, 16'h0300);
    tick();
    sendCmd(3'd0, 2'd1, 16'h0, '0);
    check("R6", "busy raised", rdBusy, 1'b1);
    repeat (10) tick();
    check("R6", "busy held while task runs", rdBusy, 1'b1);
    check("R6", "no done while task runs", rdDone, 1'b0);
    sendCmd(3'd2, 2'd3, 16'h9999, {256{1'b1}});
    check("R11", "wide load ignored while busy", wideOut, '0);
    setTable(32'h0);
    seen1 = 0;
    for (int n = 0; n < 50 && !rdDone; n++) begin
      if (issueTask == 2'd1) seen1++;
      tick();
    end
    check("R6", "done after starve", rdDone, 1'b1);
    check("R2", "starved task gets no slot", seen1, 0);
    check("R5", "snapshot after calls", wideOut,
          mkCtx(16'h0300, 0, 1, 18'h10201, 18'h10102, 0, 0, 0, 0));
    tick();
    check("R6", "done is one cycle", rdDone, 1'b0);
    setTable(32'h4444_4444);
    runT1(2'd2, 16'h0, 1, 0, 0);
    setTable(32'h0);
    readTask(2'd1, w);
    check("R4", "snapshot after return", w,
          mkCtx(16'h0201, 1, 0, 18'h10102, 0, 0, 0, 0, 0));
  endtask

  task automatic testLoads();
    logic [255:0] w, ctx2, w1, w2;
    ctx2 = mkCtx(16'h0ABC, 1, 1, 18'h3FFFF, 0, 0, 18'h2AAAA, 16'h1234, 1);
    sendCmd(3'd1, 2'd2, 16'h0, ctx2 | {{149{1'b1}}, 107'b0});
    check("R7", "no error on write", cmdErr, 1'b0);
    readTask(2'd2, w);
    check("R7", "written context, high bits dropped", w, ctx2);
    readTask(2'd3, w);
    check("R11", "task3 cache untouched by ignored load", w, '0);
    w1 = {8{32'hC0DE_0001}};
    sendCmd(3'd2, 2'd3, 16'h5555, w1);
    check("R8", "wide load data", wideOut, w1);
    readTask(2'd3, w);
    check("R8", "wide load sets cache fields", w, mkCtx(0, 0, 0, 0, 0, 0, 0, 16'h5555, 1));
    w2 = {8{32'h0BAD_F00D}};
    sendCmd(3'd3, 2'd2, 16'h7777, w2);
    check("R8", "quiet load data", wideOut, w2);
    readTask(2'd2, w);
    check("R8", "quiet load keeps cache fields", w, ctx2);
  endtask

  task automatic testStep();
    int nulls = 0;
    int bad = 0;
    setTable(32'h0000_0002);
    for (int n = 0; n < 40; n++) begin
      if (issueTask == 2'd2) begin
        nulls++;
        if (issueValid !== 1'b0 || issuePc !== 16'h0ABC) bad++;
      end
      tick();
    end
    check("R3", "stalled slots null and pc held", bad, 0);
    check("R3", "task2 slots seen", nulls > 0, 1'b1);
    sendCmd(3'd6, 2'd2, 16'h0, '0);
    waitSlot(2'd2);
    check("R9", "stepped slot valid", issueValid, 1'b1);
    check("R9", "stepped pc", issuePc, 16'h0ABC);
    exHold = 1'b1; exOp = 2'd0; exFlagWe = 1'b0;
    tick();
    exHold = 1'b0;
    waitSlot(2'd2);
    check("R9", "restalled after one step", issueValid, 1'b0);
    check("R9", "pc advanced once", issuePc, 16'h0ABD);
    sendCmd(3'd5, 2'd2, 16'h0, '0);
    waitSlot(2'd2);
    check("R12", "run command", issueValid, 1'b1);
    sendCmd(3'd4, 2'd2, 16'h0, '0);
    waitSlot(2'd2);
    check("R12", "stall command", issueValid, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; tableWrEn = 1'b0; tableIn = '0; cmdValid = 1'b0; cmdOp = '0;
    cmdTask = '0; cmdAddr = '0; wideIn = '0; exOp = 2'd3; exTarget = '0;
    exFlagWe = 1'b0; exZ = 1'b0; exC = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSelfError();
    testTable();
    testExecAndDrain();
    testLoads();
    testStep();
    finishRun();
  end
endmodule